// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block stores received frames in memory. Software sets up a closed ring of descriptors, and each descriptor points at one receive buffer. A descriptor is five 32-bit words. When the first byte of a frame arrives, the engine reads the current descriptor. If the descriptor is marked as owned by the engine, the frame bytes go one by one into the buffer. The engine then writes two status words, followed by the control word, which carries the stored length and the frame-boundary flags. Writing the control word also clears the ownership bit and returns the descriptor to software.

A descriptor that the engine does not own cannot take the frame. In that case the engine reads the frame from the source, discards it, and raises an overflow pulse. A counter tracks the frames that software has not yet handled. The counter goes up on every completed writeback, and software lowers it with a one-cycle decrement strobe. While the counter is nonzero, a pending interrupt is raised, gated by its enable input.

The memory port is a plain single-word port that is always ready. Read data returns one cycle after a read request.

Top module: `rxd_ring_writer`

## Requirements
- R1: A descriptor at byte address D has this layout: control word at D+0, buffer address at D+4, status word one at D+8, status word two at D+12, next pointer at D+16. The engine reads the control word first, after the first byte of a frame appears at the input.
- R2: A frame is stored only when control bit 7 (engine ownership) is set. The control word written back has bit 7 cleared.
- R3: If bit 7 is clear, the engine accepts the whole frame and discards it. It issues no memory write, raises `rx_overflow` for one cycle, and leaves the count unchanged. The next frame tries the same descriptor again.
- R4: The control word written back holds the stored byte count in bits 31..16, with bit 9 (start of packet) and bit 10 (end of packet) both set. Bit 8 (next-pointer-valid) is copied from the fetched control word, and all other bits are zero. This word is written after both status words.
- R5: Frame byte k is written to byte address B+k, where B is the buffer address. Each write has a single byte enable, at lane (B+k) mod 4, with the byte placed in that lane (little-endian lanes).
- R6: The storage limit is the smaller of `cfg_buf_size` and the parameter MAX_FRAME (default 1518). Bytes past the limit are not written. Status word one bits 15..0 hold the full received length. Status word two bit 1 marks a truncated frame.
- R7: Status word two has bit 7 (receive OK) set only if the frame was neither truncated nor flagged with `in_err` on any beat. Bit 0 records `in_err`, and all other bits are zero.
- R8: If the fetched bit 8 is set, the next descriptor is the word read at D+16. If bit 8 is clear, the next descriptor is D+20. While `rx_en` is low and no frame is in progress, the current pointer reloads from `cfg_ring_base`.
- R9: The count rises by one at each control-word writeback and saturates at 2^CNT_W-1. A `sw_dec` strobe lowers it by one when it is nonzero. A writeback and a strobe in the same cycle leave the count unchanged.
- R10: `pend_irq` is high exactly when `irq_en` is high and the count is nonzero.
- R11: After reset, `in_ready`, `mem_req` and the count are zero. `in_ready` stays low while `rx_en` is low and while descriptors are being fetched or written back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receive enable; when low, the pointer reloads from the ring base |
| cfg_ring_base | input | AW | Byte address of the first descriptor |
| cfg_buf_size | input | 16 | Receive buffer size in bytes |
| irq_en | input | 1 | Enable for the pending interrupt |
| sw_dec | input | 1 | One-cycle strobe that decrements the count |
| in_valid | input | 1 | A frame byte is present |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | Last byte of the frame |
| in_err | input | 1 | Frame error flag |
| in_ready | output | 1 | The engine accepts the byte |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Write when high, read when low |
| mem_addr | output | AW | Word-aligned byte address |
| mem_be | output | 4 | Byte enables |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, one cycle after the request |
| pkt_count | output | CNT_W | Count of frames not yet handled |
| pend_irq | output | 1 | Pending-frame interrupt |
| rx_overflow | output | 1 | Pulse when a frame is discarded |

## Verification
The counter increment from a control-word writeback and the software decrement strobe can land on the same clock edge. The bench knows the edge on which a frame's last byte is accepted, so it places `sw_dec` exactly on the third edge after it, the cycle in which the control word is written. It then expects the count to be unchanged. The same collision also appears at random points of the mixed stimulus, and it is judged against a model that adds and subtracts independently, with saturation at both ends.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
   localparam int WORD_W     = 32;
   localparam int LEN_W      = 16;
   localparam int CTL_OFS    = 0;
   localparam int BUF_OFS    = 4;
   localparam int ST1_OFS    = 8;
   localparam int ST2_OFS    = 12;
   localparam int NXT_OFS    = 16;
   localparam int DESC_BYTES = 20;
   localparam int OWN_BIT    = 7;
   localparam int NPV_BIT    = 8;
   localparam int SOP_BIT    = 9;
   localparam int EOP_BIT    = 10;
   localparam int LEN_LSB    = 16;
   localparam int OK_BIT     = 7;
   localparam int ERR_BIT    = 0;
   localparam int TRN_BIT    = 1;

   typedef enum logic [3:0] {
      ST_IDLE, ST_RD_CTL, ST_RD_BUF, ST_RD_NXT, ST_WT_NXT,
      ST_DATA, ST_DROP, ST_WR_S1, ST_WR_S2, ST_WR_CTL
   } rx_state_e;
endpackage

// File: rtl/rxd_lane_writer.sv
module rxd_lane_writer #(
   parameter int AW    = 32,
   parameter int OFS_W = 16,
   parameter int DW    = 32
) (
   input  logic [AW-1:0]    base,
   input  logic [OFS_W-1:0] offset,
   input  logic [7:0]       data,
   output logic [AW-1:0]    addr,
   output logic [DW/8-1:0]  be,
   output logic [DW-1:0]    wdata
);
   localparam int LANES  = DW / 8;
   localparam int LANE_W = $clog2(LANES);

   logic [AW-1:0]     sum;
   logic [LANE_W-1:0] lane;

   assign sum  = base + AW'(offset);
   assign lane = sum[LANE_W-1:0];
   assign addr = {sum[AW-1:LANE_W], {LANE_W{1'b0}}};

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign be[l]          = (lane == LANE_W'(l));
      assign wdata[8*l +: 8] = data;
   end
endmodule

// File: rtl/rxd_pkt_counter.sv
module rxd_pkt_counter #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   input  logic             dec,
   output logic [CNT_W-1:0] count
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic do_dec;
   assign do_dec = dec && (count != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
      end else if (inc && !do_dec) begin
         if (count != CNT_MAX) count <= count + 1'b1;
      end else if (do_dec && !inc) begin
         count <= count - 1'b1;
      end
   end
endmodule

// File: rtl/rxd_ring_writer.sv
module rxd_ring_writer
   import rxd_pkg::*;
#(
   parameter int AW        = 32,
   parameter int CNT_W     = 4,
   parameter int MAX_FRAME = 1518
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rx_en,
   input  logic [AW-1:0]    cfg_ring_base,
   input  logic [15:0]      cfg_buf_size,
   input  logic             irq_en,
   input  logic             sw_dec,
   input  logic             in_valid,
   input  logic [7:0]       in_data,
   input  logic             in_last,
   input  logic             in_err,
   output logic             in_ready,
   output logic             mem_req,
   output logic             mem_we,
   output logic [AW-1:0]    mem_addr,
   output logic [3:0]       mem_be,
   output logic [31:0]      mem_wdata,
   input  logic [31:0]      mem_rdata,
   output logic [CNT_W-1:0] pkt_count,
   output logic             pend_irq,
   output logic             rx_overflow
);
   localparam logic [LEN_W-1:0] FRAME_CAP = LEN_W'(MAX_FRAME);

   if (AW < 8 || AW > WORD_W) begin : g_bad_aw
      $error("rxd_ring_writer: AW must lie in 8..32");
   end
   if (CNT_W < 1 || CNT_W > 16) begin : g_bad_cnt
      $error("rxd_ring_writer: CNT_W must lie in 1..16");
   end
   if (MAX_FRAME < 1 || MAX_FRAME > 65535) begin : g_bad_max
      $error("rxd_ring_writer: MAX_FRAME must lie in 1..65535");
   end

   rx_state_e        state;
   logic [AW-1:0]    cur_q, buf_q, nxt_q;
   logic             npv_q;
   logic [LEN_W-1:0] rx_len;
   logic             err_q;
   logic [LEN_W-1:0] limit, stored_len;
   logic             trunc, store_byte, ctl_wb;
   logic [AW-1:0]    lane_addr;
   logic [3:0]       lane_be;
   logic [31:0]      lane_data;
   logic [31:0]      st2_word, ctl_word;

   assign limit      = (cfg_buf_size < FRAME_CAP) ? cfg_buf_size : FRAME_CAP;
   assign trunc      = rx_len > limit;
   assign stored_len = trunc ? limit : rx_len;
   assign store_byte = (state == ST_DATA) && in_valid && (rx_len < limit);
   assign ctl_wb     = (state == ST_WR_CTL);
   assign in_ready   = (state == ST_DATA) || (state == ST_DROP);
   assign rx_overflow = (state == ST_RD_BUF) && !mem_rdata[OWN_BIT];

   rxd_lane_writer #(.AW(AW), .OFS_W(LEN_W), .DW(WORD_W)) u_lane (
      .base   (buf_q),
      .offset (rx_len),
      .data   (in_data),
      .addr   (lane_addr),
      .be     (lane_be),
      .wdata  (lane_data)
   );

   always_comb begin
      st2_word          = '0;
      st2_word[OK_BIT]  = !err_q && !trunc;
      st2_word[TRN_BIT] = trunc;
      st2_word[ERR_BIT] = err_q;
      ctl_word          = '0;
      ctl_word[31:LEN_LSB] = stored_len;
      ctl_word[SOP_BIT] = 1'b1;
      ctl_word[EOP_BIT] = 1'b1;
      ctl_word[NPV_BIT] = npv_q;
   end

   always_comb begin
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = cur_q;
      mem_be    = 4'hF;
      mem_wdata = '0;
      unique case (state)
         ST_RD_CTL: begin
            mem_req  = 1'b1;
            mem_addr = cur_q + AW'(CTL_OFS);
         end
         ST_RD_BUF: begin
            mem_req  = mem_rdata[OWN_BIT];
            mem_addr = cur_q + AW'(BUF_OFS);
         end
         ST_RD_NXT: begin
            mem_req  = 1'b1;
            mem_addr = cur_q + AW'(NXT_OFS);
         end
         ST_DATA: begin
            mem_req   = store_byte;
            mem_we    = 1'b1;
            mem_addr  = lane_addr;
            mem_be    = lane_be;
            mem_wdata = lane_data;
         end
         ST_WR_S1: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = cur_q + AW'(ST1_OFS);
            mem_wdata = {16'h0000, rx_len};
         end
         ST_WR_S2: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = cur_q + AW'(ST2_OFS);
            mem_wdata = st2_word;
         end
         ST_WR_CTL: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = cur_q + AW'(CTL_OFS);
            mem_wdata = ctl_word;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         cur_q  <= '0;
         buf_q  <= '0;
         nxt_q  <= '0;
         npv_q  <= 1'b0;
         rx_len <= '0;
         err_q  <= 1'b0;
      end else begin
         unique case (state)
            ST_IDLE: begin
               if (!rx_en) cur_q <= cfg_ring_base;
               else if (in_valid) state <= ST_RD_CTL;
            end
            ST_RD_CTL: state <= ST_RD_BUF;
            ST_RD_BUF: begin
               npv_q <= mem_rdata[NPV_BIT];
               state <= mem_rdata[OWN_BIT] ? ST_RD_NXT : ST_DROP;
            end
            ST_RD_NXT: begin
               buf_q <= mem_rdata[AW-1:0];
               state <= ST_WT_NXT;
            end
            ST_WT_NXT: begin
               nxt_q  <= npv_q ? mem_rdata[AW-1:0] : cur_q + AW'(DESC_BYTES);
               rx_len <= '0;
               err_q  <= 1'b0;
               state  <= ST_DATA;
            end
            ST_DATA: begin
               if (in_valid) begin
                  rx_len <= rx_len + 1'b1;
                  err_q  <= err_q | in_err;
                  if (in_last) state <= ST_WR_S1;
               end
            end
            ST_DROP:   if (in_valid && in_last) state <= ST_IDLE;
            ST_WR_S1:  state <= ST_WR_S2;
            ST_WR_S2:  state <= ST_WR_CTL;
            ST_WR_CTL: begin
               cur_q <= nxt_q;
               state <= ST_IDLE;
            end
            default:   state <= ST_IDLE;
         endcase
      end
   end

   rxd_pkt_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (ctl_wb),
      .dec   (sw_dec),
      .count (pkt_count)
   );

   assign pend_irq = irq_en && (pkt_count != '0);
endmodule

// File: rtl/rxd_ring_checker.sv
module rxd_ring_checker #(
   parameter int CNT_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             irq_en,
   input logic             sw_dec,
   input logic             in_ready,
   input logic             mem_req,
   input logic             mem_we,
   input logic [31:0]      mem_wdata,
   input logic [CNT_W-1:0] pkt_count,
   input logic             pend_irq,
   input logic             rx_overflow,
   input logic             ctl_wb
);
   localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

   a_r2_own_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_wb |-> (mem_req && mem_we && !mem_wdata[7]));

   a_r4_boundary_flags: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_wb |-> (mem_wdata[9] && mem_wdata[10]));

   a_r3_drop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      rx_overflow |=> (in_ready && !mem_req));

   a_r9_increment: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wb && !sw_dec && pkt_count != CMAX) |=> pkt_count == CNT_W'($past(pkt_count) + 1'b1));

   a_r9_saturate: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wb && !sw_dec && pkt_count == CMAX) |=> pkt_count == CMAX);

   a_r9_decrement: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl_wb && sw_dec && pkt_count != '0) |=> pkt_count == CNT_W'($past(pkt_count) - 1'b1));

   a_r9_collide: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wb && sw_dec && pkt_count != '0) |=> $stable(pkt_count));

   a_r10_gated: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_en |-> !pend_irq);
endmodule

bind rxd_ring_writer rxd_ring_checker #(.CNT_W(CNT_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .irq_en      (irq_en),
   .sw_dec      (sw_dec),
   .in_ready    (in_ready),
   .mem_req     (mem_req),
   .mem_we      (mem_we),
   .mem_wdata   (mem_wdata),
   .pkt_count   (pkt_count),
   .pend_irq    (pend_irq),
   .rx_overflow (rx_overflow),
   .ctl_wb      (ctl_wb)
);

// File: tb/rxd_ring_writer_tb_top.sv
`timescale 1ns/1ps
module rxd_ring_writer_tb_top;
   localparam int AW    = 32;
   localparam int CNT_W = 4;
   localparam int MAXF  = 80;
   localparam int CMAX  = (1 << CNT_W) - 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rx_en = 1'b0, irq_en = 1'b0, sw_dec = 1'b0;
   logic [AW-1:0] cfg_ring_base = 32'h100;
   logic [15:0] cfg_buf_size = 16'd64;
   logic in_valid = 1'b0, in_last = 1'b0, in_err = 1'b0;
   logic [7:0] in_data = 8'h00;
   logic in_ready, mem_req, mem_we, pend_irq, rx_overflow;
   logic [AW-1:0] mem_addr;
   logic [3:0] mem_be;
   logic [31:0] mem_wdata, mem_rdata;
   logic [CNT_W-1:0] pkt_count;

   always #2.5 clk = ~clk;

   rxd_ring_writer #(.AW(AW), .CNT_W(CNT_W), .MAX_FRAME(MAXF)) dut_i (
      .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .cfg_ring_base(cfg_ring_base),
      .cfg_buf_size(cfg_buf_size), .irq_en(irq_en), .sw_dec(sw_dec),
      .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_err(in_err),
      .in_ready(in_ready), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .pkt_count(pkt_count), .pend_irq(pend_irq), .rx_overflow(rx_overflow)
   );

   logic [31:0] mem_arr [0:1023];
   always @(posedge clk) begin
      if (mem_req && !mem_we) mem_rdata <= mem_arr[mem_addr[11:2]];
      if (mem_req && mem_we)
         for (int b = 0; b < 4; b++)
            if (mem_be[b]) mem_arr[mem_addr[11:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
   end

   int ovf_n = 0, wr_n = 0;
   always @(posedge clk) if (rst_n) begin
      if (rx_overflow) ovf_n++;
      if (mem_req && mem_we) wr_n++;
   end

   int n_chk = 0, n_bad = 0;
   bit done = 1'b0;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   int unsigned ring_d [3] = '{32'h100, 32'h180, 32'h194};
   int unsigned ring_b [3] = '{32'h400, 32'h480, 32'h500};
   bit          ring_n [3] = '{1'b1, 1'b0, 1'b1};
   int sw_idx = 0;
   int exp_cnt = 0;
   logic [7:0] fb [0:255];

   function automatic logic [7:0] rd_byte(input int unsigned a);
      return mem_arr[a >> 2][8*(a % 4) +: 8];
   endfunction

   function automatic logic [31:0] exp_ctl(input int stored, input bit npv);
      logic [31:0] e = '0;
      e[31:16] = stored[15:0];
      e[10] = 1'b1; e[9] = 1'b1; e[8] = npv;
      return e;
   endfunction

   function automatic logic [31:0] exp_st2(input bit err, input bit trn);
      logic [31:0] e = '0;
      e[7] = !err && !trn; e[1] = trn; e[0] = err;
      return e;
   endfunction

   task automatic arm(input int i);
      logic [31:0] c = '0;
      c[7] = 1'b1; c[8] = ring_n[i];
      mem_arr[ring_d[i] >> 2] = c;
      mem_arr[(ring_d[i] + 4) >> 2] = ring_b[i];
      mem_arr[(ring_d[i] + 8) >> 2] = '0;
      mem_arr[(ring_d[i] + 12) >> 2] = '0;
      if (ring_n[i]) mem_arr[(ring_d[i] + 16) >> 2] = ring_d[(i + 1) % 3];
      for (int w = 0; w < 32; w++) mem_arr[(ring_b[i] >> 2) + w] = 32'hA5A5A5A5;
   endtask

   task automatic dec_pulse();
      @(negedge clk); sw_dec = 1'b1;
      @(negedge clk); sw_dec = 1'b0;
      if (exp_cnt > 0) exp_cnt--;
   endtask

   // drives one frame; leaves time at negedge 3.5 cycles after the last accept
   task automatic send(input int len, input bit err, input bit dec_wb);
      bit rdy;
      for (int k = 0; k < len; k++) begin
         @(negedge clk);
         in_valid = 1'b1; in_data = fb[k]; in_last = (k == len - 1); in_err = err && (k == len - 1);
         forever begin
            #1 rdy = in_ready;
            @(posedge clk);
            if (rdy) break;
            @(negedge clk);
         end
      end
      @(negedge clk); in_valid = 1'b0; in_last = 1'b0; in_err = 1'b0;
      @(negedge clk);
      @(negedge clk); if (dec_wb) sw_dec = 1'b1;
      @(negedge clk); sw_dec = 1'b0;
   endtask

   task automatic frame_and_check(input int len, input bit err, input bit dec_wb, input string tag);
      int lim, stored;
      bit trn, bytes_ok;
      int unsigned d, b;
      for (int k = 0; k < len; k++) fb[k] = 8'($urandom);
      lim = (cfg_buf_size < MAXF) ? int'(cfg_buf_size) : MAXF;
      stored = (len > lim) ? lim : len;
      trn = len > lim;
      d = ring_d[sw_idx]; b = ring_b[sw_idx];
      send(len, err, dec_wb);
      if (!dec_wb || exp_cnt == 0) exp_cnt = (exp_cnt < CMAX) ? exp_cnt + 1 : CMAX;
      chk(mem_arr[d >> 2] == exp_ctl(stored, ring_n[sw_idx]), "R4", {tag, " control word R2"},
          mem_arr[d >> 2], exp_ctl(stored, ring_n[sw_idx]));
      chk(mem_arr[(d + 12) >> 2] == exp_st2(err, trn), "R7", {tag, " status two R6"},
          mem_arr[(d + 12) >> 2], exp_st2(err, trn));
      chk(mem_arr[(d + 8) >> 2] == 32'(len), "R6", {tag, " status one length"},
          mem_arr[(d + 8) >> 2], len);
      bytes_ok = 1'b1;
      for (int k = 0; k < stored; k++) if (rd_byte(b + k) != fb[k]) bytes_ok = 1'b0;
      if (stored < 128 && rd_byte(b + stored) != 8'hA5) bytes_ok = 1'b0;
      chk(bytes_ok, "R5", {tag, " buffer bytes and guard R1"}, bytes_ok, 1);
      chk(int'(pkt_count) == exp_cnt, "R9", {tag, " count"}, pkt_count, exp_cnt);
      chk(pend_irq == (irq_en && exp_cnt != 0), "R10", {tag, " pending"}, pend_irq, irq_en && exp_cnt != 0);
      arm(sw_idx);
      sw_idx = (sw_idx + 1) % 3;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++; n_bad++;
         $display("FAIL watchdog run did not finish actual=0 expected=1");
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      int w0, o0;
      void'($urandom(32'd20240611));
      for (int i = 0; i < 1024; i++) mem_arr[i] = '0;
      for (int i = 0; i < 3; i++) arm(i);
      repeat (4) @(negedge clk);
      chk(in_ready == 0 && mem_req == 0, "R11", "reset ready/req", {in_ready, mem_req}, 0);
      chk(pkt_count == 0 && pend_irq == 0, "R11", "reset count", pkt_count, 0);
      rst_n = 1'b1;

      // disabled: byte present but never taken
      @(negedge clk); in_valid = 1'b1; in_data = 8'h11;
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         chk(in_ready == 0 && mem_req == 0, "R11", "disabled no accept", in_ready, 0);
      end
      in_valid = 1'b0;
      @(negedge clk); rx_en = 1'b1;

      // directed frames
      frame_and_check(1, 0, 0, "len1");
      frame_and_check(64, 0, 0, "exact fit");
      frame_and_check(65, 0, 0, "one over R6");
      frame_and_check(10, 1, 0, "error R7");
      chk(pend_irq == 0, "R10", "gated off", pend_irq, 0);
      @(negedge clk); irq_en = 1'b1; #1;
      chk(pend_irq == 1, "R10", "enabled", pend_irq, 1);
      while (exp_cnt > 0) dec_pulse();
      @(negedge clk);
      chk(pkt_count == 0 && pend_irq == 0, "R9", "drained R10", pkt_count, 0);
      dec_pulse();
      chk(pkt_count == 0, "R9", "dec at zero", pkt_count, 0);

      // collision of writeback and decrement
      frame_and_check(5, 0, 0, "pre collide");
      frame_and_check(7, 0, 1, "collide R9");

      // not-owned descriptor
      mem_arr[ring_d[sw_idx] >> 2][7] = 1'b0;
      w0 = wr_n; o0 = ovf_n;
      for (int k = 0; k < 20; k++) fb[k] = 8'(k);
      send(20, 0, 0);
      chk(ovf_n - o0 == 1, "R3", "overflow pulses", ovf_n - o0, 1);
      chk(wr_n == w0, "R3", "no writes on drop", wr_n - w0, 0);
      chk(int'(pkt_count) == exp_cnt, "R3", "count held", pkt_count, exp_cnt);
      arm(sw_idx);
      frame_and_check(12, 0, 0, "retry same slot R3");

      // frame cap below buffer size
      cfg_buf_size = 16'd100;
      frame_and_check(90, 0, 0, "cap R6");
      frame_and_check(80, 0, 0, "at cap R6");

      // random mix
      for (int n = 0; n < 40; n++) begin
         cfg_buf_size = ($urandom_range(0, 1) != 0) ? 16'd100 : 16'd64;
         frame_and_check($urandom_range(1, 100), $urandom_range(0, 9) == 0,
                         exp_cnt > 0 && $urandom_range(0, 3) == 0, "random R8");
         if ($urandom_range(0, 2) == 0) dec_pulse();
      end

      // saturation
      for (int n = 0; n < CMAX + 2; n++) frame_and_check(3, 0, 0, "saturate R9");
      chk(int'(pkt_count) == CMAX, "R9", "held at max", pkt_count, CMAX);

      // reload of pointer from ring base
      if (sw_idx == 0) frame_and_check(4, 0, 0, "step");
      @(negedge clk); rx_en = 1'b0;
      repeat (3) @(negedge clk);
      rx_en = 1'b1; sw_idx = 0;
      frame_and_check(9, 0, 0, "reload R8");

      if (!done) begin
         done = 1'b1;
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule